// File: doc/BRIEF.md
# Read/Write Preamplifier Mode and Head-Select Controller

This block is the digital control core of a twelve-head read/write preamplifier. It takes the operating-mode field, the head-select code and a dual-head servo-write bit from a small configuration store. It also takes the read/write pin, the servo-write pin, the two chip-identity pins and a fault-detector flag. From these it drives one-hot reader and writer head enables, the spare (dummy) head select, the write-current enable, the reader bias enable, the output-enable controls for the shared read-data and fault lines, and the level driven on the fault line.

Mode changes follow a guarded sequence. Writing is reachable only from active reading, and only through one gap cycle in which no head is enabled. Returning to reading also passes through a gap cycle after the write enable has fallen. An out-of-range head code parks the device on the dummy head with the writer disabled and reports a fault. While the reset pin is low, the configuration store stays at its power-up values: sleep, head 0, dual-head off.

All outputs are registered. A change on a pin reaches the outputs at the next rising clock edge. A configuration write is captured at one edge and reaches the outputs at the edge after that.

Top module: `preamp_ctrl`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, the block is in sleep. All head enables, `wr_en`, `mr_bias_en`, `dummy_sel`, `rd_out_oe`, `flt_oe` and `flt_level` are 0.
- R2: While `cfg_hold_n` is low, `cfg_we` is ignored and the stored mode, head and dual bit stay at sleep (00), head 0 and off. A write of the active mode during the hold leaves the outputs in sleep.
- R3: The mode field is decoded as 00 sleep, 01 standby, 10 active and 11 standby. In active mode with `rw_n` high, exactly the bit of `rd_head_en` for the stored head code is set, and `mr_bias_en`, `rd_out_oe` and `flt_oe` are 1. A pin change shows at the outputs one edge later, and a configuration write shows two edges later.
- R4: A write request (`rw_n` low) in sleep or standby is ignored. This includes switching the mode to active while `rw_n` is already low: the block stays idle and `wr_en` remains 0.
- R5: From active read, `rw_n` going low gives one gap cycle with all head enables, `mr_bias_en` and `wr_en` at 0. Then `wr_en` is 1 and `wr_head_en` holds the selected head. `wr_en` never rises in a cycle that follows a cycle with a reader enabled.
- R6: From write, `rw_n` going high first clears `wr_en` and all head enables for one cycle, and only then enables the reader.
- R7: A head code of 12 or above sets `dummy_sel` in every active state, clears every reader and writer enable, keeps `wr_en` at 0 and signals a fault on the fault line.
- R8: The fault condition is an invalid head code or `flt_det` high. In read and gap states, `flt_level` is 0 on a fault and 1 otherwise. In write, `flt_level` is 1 on a fault and 0 otherwise.
- R9: When the stored dual bit is 1, `stw_n` is 0, both `chip_id` bits are 1 and the head code x is below 6, write enables heads x and x+6 together while read enables only head x. If any of these conditions is missing, write enables head x alone.
- R10: In sleep and standby, `rd_out_oe`, `flt_oe`, `mr_bias_en`, `wr_en` and every head enable are 0.
- R11: Leaving the active mode from write goes straight to sleep or standby at the next output update, with `wr_en` and `wr_head_en` cleared at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_hold_n | input | 1 | Register-hold pin; low keeps configuration at defaults |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Mode field to store |
| cfg_head | input | 4 | Head code to store |
| cfg_dual | input | 1 | Dual-head servo-write bit to store |
| rw_n | input | 1 | Read (1) / write (0) request pin |
| stw_n | input | 1 | Servo-write qualifier, active low |
| chip_id | input | 2 | Chip identity pins |
| flt_det | input | 1 | Fault detector flag, active high |
| rd_head_en | output | 12 | One-hot reader head enables |
| wr_head_en | output | 12 | Writer head enables |
| dummy_sel | output | 1 | Dummy head selected |
| wr_en | output | 1 | Write current enable |
| mr_bias_en | output | 1 | Reader bias enable |
| rd_out_oe | output | 1 | Read-data output drive enable |
| flt_oe | output | 1 | Fault line drive enable |
| flt_level | output | 1 | Level driven on the fault line |

## Verification
Every output comes straight from the state register. A wrong state therefore shows at the ports on the very edge where it is taken. Examples are skipping the gap, entering write from standby, or keeping a head after an invalid code. It shows as a stray head enable, a write enable with a reader still enabled in the prior cycle, or an inverted fault level. A stale or wrongly held configuration register shows two edges after the write, as an unchanged or wrong head bit. The bench's per-clock comparison against the behavioural model catches any such error within one cycle of its appearance.

// File: rtl/preamp_ctrl_pkg.sv
package preamp_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_SLEEP = 3'd0,
        ST_STBY  = 3'd1,
        ST_READ  = 3'd2,
        ST_R2W   = 3'd3,
        ST_WRITE = 3'd4,
        ST_W2R   = 3'd5
    } pstate_e;

    localparam logic [1:0] MODE_SLEEP  = 2'b00;
    localparam logic [1:0] MODE_ACTIVE = 2'b10;

endpackage

// File: rtl/preamp_cfg_regs.sv
module preamp_cfg_regs #(
    parameter int HEAD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_n,
    input  logic              we,
    input  logic [1:0]        mode_in,
    input  logic [HEAD_W-1:0] head_in,
    input  logic              dual_in,
    output logic [1:0]        mode_q,
    output logic [HEAD_W-1:0] head_q,
    output logic              dual_q
);
    import preamp_ctrl_pkg::*;

    typedef struct packed {
        logic [1:0]        mode;
        logic [HEAD_W-1:0] head;
        logic              dual;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!hold_n) begin
            cfg_d = '{mode: MODE_SLEEP, head: '0, dual: 1'b0};
        end else if (we) begin
            cfg_d = '{mode: mode_in, head: head_in, dual: dual_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '{mode: MODE_SLEEP, head: '0, dual: 1'b0};
        else        cfg_q <= cfg_d;
    end

    assign mode_q = cfg_q.mode;
    assign head_q = cfg_q.head;
    assign dual_q = cfg_q.dual;

    // R2: a held reset pin leaves the store at its defaults one edge later
    a_r2_hold_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_n |=> (mode_q == MODE_SLEEP && head_q == '0 && !dual_q));

endmodule

// File: rtl/preamp_head_dec.sv
module preamp_head_dec #(
    parameter int NUM_HEADS = 12,
    parameter int HEAD_W    = 4
) (
    input  logic [HEAD_W-1:0]    head,
    input  logic                 dual_ok,
    output logic                 valid,
    output logic [NUM_HEADS-1:0] rd_mask,
    output logic [NUM_HEADS-1:0] wr_mask
);
    localparam int HALF = NUM_HEADS / 2;

    assign valid = (32'(head) < NUM_HEADS);

    for (genvar g = 0; g < NUM_HEADS; g++) begin : g_head
        assign rd_mask[g] = valid && (head == HEAD_W'(g));
        if (g >= HALF) begin : g_upper
            // upper-half writer also fires as the partner of head g-HALF
            assign wr_mask[g] = rd_mask[g] || (dual_ok && head == HEAD_W'(g - HALF));
        end else begin : g_lower
            assign wr_mask[g] = rd_mask[g];
        end
    end

endmodule

// File: rtl/preamp_ctrl.sv
module preamp_ctrl #(
    parameter int NUM_HEADS = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_hold_n,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_mode,
    input  logic [3:0]           cfg_head,
    input  logic                 cfg_dual,
    input  logic                 rw_n,
    input  logic                 stw_n,
    input  logic [1:0]           chip_id,
    input  logic                 flt_det,
    output logic [NUM_HEADS-1:0] rd_head_en,
    output logic [NUM_HEADS-1:0] wr_head_en,
    output logic                 dummy_sel,
    output logic                 wr_en,
    output logic                 mr_bias_en,
    output logic                 rd_out_oe,
    output logic                 flt_oe,
    output logic                 flt_level
);
    import preamp_ctrl_pkg::*;

    localparam int HEAD_W = 4;

    typedef struct packed {
        pstate_e              st;
        logic [NUM_HEADS-1:0] rd_head;
        logic [NUM_HEADS-1:0] wr_head;
        logic                 dummy;
        logic                 wen;
        logic                 bias;
        logic                 rd_oe;
        logic                 f_oe;
        logic                 f_lvl;
    } ctl_t;

    logic [1:0]           mode_q;
    logic [HEAD_W-1:0]    head_q;
    logic                 dual_q;
    logic                 head_ok;
    logic                 dual_ok;
    logic [NUM_HEADS-1:0] rd_mask;
    logic [NUM_HEADS-1:0] wr_mask;

    ctl_t ctl_d, ctl_q;

    preamp_cfg_regs #(.HEAD_W(HEAD_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold_n  (cfg_hold_n),
        .we      (cfg_we),
        .mode_in (cfg_mode),
        .head_in (cfg_head),
        .dual_in (cfg_dual),
        .mode_q  (mode_q),
        .head_q  (head_q),
        .dual_q  (dual_q)
    );

    assign dual_ok = dual_q && !stw_n && (&chip_id);

    preamp_head_dec #(.NUM_HEADS(NUM_HEADS), .HEAD_W(HEAD_W)) u_dec (
        .head    (head_q),
        .dual_ok (dual_ok),
        .valid   (head_ok),
        .rd_mask (rd_mask),
        .wr_mask (wr_mask)
    );

    always_comb begin
        logic    active;
        logic    in_act;
        logic    fault;
        pstate_e idle_st;
        pstate_e nxt;

        active  = (mode_q == MODE_ACTIVE);
        idle_st = (mode_q == MODE_SLEEP) ? ST_SLEEP : ST_STBY;
        nxt     = ctl_q.st;

        unique case (ctl_q.st)
            ST_SLEEP, ST_STBY: begin
                if (!active)   nxt = idle_st;
                else if (rw_n) nxt = ST_READ;
                else           nxt = ctl_q.st;  // write request from idle is ignored
            end
            ST_READ:  nxt = !active ? idle_st : (rw_n ? ST_READ : ST_R2W);
            ST_R2W:   nxt = !active ? idle_st : (rw_n ? ST_READ : ST_WRITE);
            ST_WRITE: nxt = !active ? idle_st : (rw_n ? ST_W2R  : ST_WRITE);
            ST_W2R:   nxt = !active ? idle_st : (rw_n ? ST_READ : ST_R2W);
            default:  nxt = ST_SLEEP;
        endcase

        in_act = (nxt == ST_READ) || (nxt == ST_R2W) || (nxt == ST_WRITE) || (nxt == ST_W2R);
        fault  = !head_ok || flt_det;

        ctl_d         = '0;
        ctl_d.st      = nxt;
        ctl_d.rd_head = (nxt == ST_READ)  ? rd_mask : '0;
        ctl_d.wr_head = (nxt == ST_WRITE) ? wr_mask : '0;
        ctl_d.wen     = (nxt == ST_WRITE) && head_ok;
        ctl_d.bias    = (nxt == ST_READ);
        ctl_d.dummy   = in_act && !head_ok;
        ctl_d.rd_oe   = in_act;
        ctl_d.f_oe    = in_act;
        if (in_act) ctl_d.f_lvl = (nxt == ST_WRITE) ? fault : !fault;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_SLEEP;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rd_head_en = ctl_q.rd_head;
    assign wr_head_en = ctl_q.wr_head;
    assign dummy_sel  = ctl_q.dummy;
    assign wr_en      = ctl_q.wen;
    assign mr_bias_en = ctl_q.bias;
    assign rd_out_oe  = ctl_q.rd_oe;
    assign flt_oe     = ctl_q.f_oe;
    assign flt_level  = ctl_q.f_lvl;

    a_r3_reader_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_head_en));

    a_r9_writer_pair_max: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wr_head_en) <= 2);

    a_r4_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_q.st) == ST_SLEEP || $past(ctl_q.st) == ST_STBY)
        |-> (ctl_q.st != ST_WRITE && ctl_q.st != ST_R2W && ctl_q.st != ST_W2R));

    a_r5_write_via_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_WRITE && $past(ctl_q.st) != ST_WRITE) |-> $past(ctl_q.st) == ST_R2W);

    a_r5_wen_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> ($past(rd_head_en) == '0 && !$past(mr_bias_en)));

    a_r6_reader_after_wen: assert property (@(posedge clk) disable iff (!rst_n)
        (|rd_head_en) |-> (!wr_en && !$past(wr_en)));

    a_r7_dummy_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        dummy_sel |-> (rd_head_en == '0 && wr_head_en == '0 && !wr_en));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_out_oe |-> (!flt_oe && !mr_bias_en && !wr_en && wr_head_en == '0 && rd_head_en == '0));

endmodule

// File: tb/preamp_ctrl_test.sv
module preamp_ctrl_test;
    localparam int NH = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_hold_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic [3:0] cfg_head = 4'd0;
    logic cfg_dual = 1'b0;
    logic rw_n = 1'b1;
    logic stw_n = 1'b1;
    logic [1:0] chip_id = 2'b00;
    logic flt_det = 1'b0;

    logic [NH-1:0] rd_head_en, wr_head_en;
    logic dummy_sel, wr_en, mr_bias_en, rd_out_oe, flt_oe, flt_level;

    preamp_ctrl #(.NUM_HEADS(NH)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_hold_n(cfg_hold_n), .cfg_we(cfg_we),
        .cfg_mode(cfg_mode), .cfg_head(cfg_head), .cfg_dual(cfg_dual),
        .rw_n(rw_n), .stw_n(stw_n), .chip_id(chip_id), .flt_det(flt_det),
        .rd_head_en(rd_head_en), .wr_head_en(wr_head_en), .dummy_sel(dummy_sel),
        .wr_en(wr_en), .mr_bias_en(mr_bias_en), .rd_out_oe(rd_out_oe),
        .flt_oe(flt_oe), .flt_level(flt_level)
    );

    always #5 clk = ~clk;

    int vectors = 0;
    int errors = 0;
    int cyc = 0;

    // model: 0 sleep, 1 standby, 2 read, 3 read-to-write gap, 4 write, 5 write-to-read gap
    int m_st = 0;
    int m_mode = 0;
    int m_head = 0;
    bit m_dual = 0;
    logic [NH-1:0] e_rd = '0, e_wr = '0;
    bit e_dummy = 0, e_wen = 0, e_bias = 0, e_rdoe = 0, e_foe = 0, e_flvl = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_mode = 0; m_head = 0; m_dual = 0;
            e_rd = '0; e_wr = '0;
            e_dummy = 0; e_wen = 0; e_bias = 0; e_rdoe = 0; e_foe = 0; e_flvl = 0;
        end else begin
            int idle;
            int nx;
            bit act, ok, pair, flt;
            act  = (m_mode == 2);
            idle = (m_mode == 0) ? 0 : 1;
            if (!act) nx = idle;
            else if (m_st <= 1) nx = rw_n ? 2 : m_st;
            else if (m_st == 4) nx = rw_n ? 5 : 4;
            else nx = rw_n ? 2 : ((m_st == 3) ? 4 : 3);
            ok   = (m_head < NH);
            pair = m_dual && !stw_n && chip_id == 2'b11 && m_head < NH / 2;
            flt  = !ok || flt_det;
            e_rd = '0; e_wr = '0;
            if (nx == 2 && ok) e_rd[m_head] = 1'b1;
            if (nx == 4 && ok) begin
                e_wr[m_head] = 1'b1;
                if (pair) e_wr[m_head + NH / 2] = 1'b1;
            end
            e_wen   = (nx == 4) && ok;
            e_bias  = (nx == 2);
            e_rdoe  = (nx >= 2);
            e_foe   = (nx >= 2);
            e_dummy = (nx >= 2) && !ok;
            e_flvl  = (nx < 2) ? 1'b0 : ((nx == 4) ? flt : !flt);
            m_st = nx;
            // configuration store updates after the state step uses its old value
            if (!cfg_hold_n) begin
                m_mode = 0; m_head = 0; m_dual = 0;
            end else if (cfg_we) begin
                m_mode = (cfg_mode == 2'b11) ? 1 : int'(cfg_mode);
                m_head = int'(cfg_head);
                m_dual = cfg_dual;
            end
        end
    end

    task automatic cmp(input string tag);
        vectors++;
        if (rd_head_en !== e_rd || wr_head_en !== e_wr || dummy_sel !== e_dummy ||
            wr_en !== e_wen || mr_bias_en !== e_bias || rd_out_oe !== e_rdoe ||
            flt_oe !== e_foe || flt_level !== e_flvl) begin
            errors++;
            $display("FAIL %s t=%0t actual rd=%h wr=%h dm=%b we=%b b=%b oe=%b foe=%b fl=%b expected rd=%h wr=%h dm=%b we=%b b=%b oe=%b foe=%b fl=%b",
                     tag, $time, rd_head_en, wr_head_en, dummy_sel, wr_en, mr_bias_en,
                     rd_out_oe, flt_oe, flt_level, e_rd, e_wr, e_dummy, e_wen, e_bias,
                     e_rdoe, e_foe, e_flvl);
        end
    endtask

    task automatic chk_bit(input string tag, input logic act_v, input logic exp_v);
        vectors++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s actual %b expected %b", tag, act_v, exp_v);
        end
    endtask

    task automatic chk_vec(input string tag, input logic [NH-1:0] act_v, input logic [NH-1:0] exp_v);
        vectors++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act_v, exp_v);
        end
    endtask

    always @(negedge clk) if (rst_n) cmp("R3/R5/R7/R8/R10 per-clock model");

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wcfg(input logic [1:0] md, input logic [3:0] hd, input logic du);
        cfg_we = 1'b1; cfg_mode = md; cfg_head = hd; cfg_dual = du;
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            report();
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1: reset state
        chk_bit("R1 rd_out_oe", rd_out_oe, 1'b0);
        chk_vec("R1 rd_head_en", rd_head_en, '0);
        chk_bit("R1 wr_en", wr_en, 1'b0);
        // R2: write during hold is dropped
        wcfg(2'b10, 4'd3, 1'b0);
        step(3);
        chk_bit("R2 still sleep", rd_out_oe, 1'b0);
        cfg_hold_n = 1'b1;
        step(1);
        // R10: standby
        wcfg(2'b01, 4'd3, 1'b0);
        step(2);
        chk_bit("R10 standby rd_out_oe", rd_out_oe, 1'b0);
        chk_bit("R10 standby flt_oe", flt_oe, 1'b0);
        // R4: write request in standby, then active while rw_n low
        rw_n = 1'b0;
        step(2);
        chk_bit("R4 standby write ignored", wr_en, 1'b0);
        wcfg(2'b10, 4'd3, 1'b0);
        step(3);
        chk_bit("R4 active with rw_n low stays idle", wr_en, 1'b0);
        chk_bit("R4 idle oe", rd_out_oe, 1'b0);
        // R3: active read on head 3
        rw_n = 1'b1;
        step(1);
        chk_vec("R3 reader head 3", rd_head_en, 12'h008);
        chk_bit("R3 bias", mr_bias_en, 1'b1);
        chk_bit("R8 read no-fault level", flt_level, 1'b1);
        // R5: read to write via a gap
        rw_n = 1'b0;
        step(1);
        chk_vec("R5 gap reader off", rd_head_en, '0);
        chk_bit("R5 gap wr_en", wr_en, 1'b0);
        step(1);
        chk_bit("R5 wr_en", wr_en, 1'b1);
        chk_vec("R5 writer head 3", wr_head_en, 12'h008);
        chk_bit("R8 write no-fault level", flt_level, 1'b0);
        flt_det = 1'b1;
        step(1);
        chk_bit("R8 write fault high", flt_level, 1'b1);
        flt_det = 1'b0;
        // R6: write to read via a gap
        rw_n = 1'b1;
        step(1);
        chk_bit("R6 wen cleared", wr_en, 1'b0);
        chk_vec("R6 reader still off", rd_head_en, '0);
        step(1);
        chk_vec("R6 reader on", rd_head_en, 12'h008);
        flt_det = 1'b1;
        step(1);
        chk_bit("R8 read fault low", flt_level, 1'b0);
        flt_det = 1'b0;
        // R7: invalid head
        wcfg(2'b10, 4'd13, 1'b0);
        step(1);
        chk_bit("R7 dummy", dummy_sel, 1'b1);
        chk_vec("R7 reader off", rd_head_en, '0);
        chk_bit("R7 fault in read", flt_level, 1'b0);
        rw_n = 1'b0;
        step(2);
        chk_bit("R7 no wr_en", wr_en, 1'b0);
        chk_bit("R7 fault in write", flt_level, 1'b1);
        rw_n = 1'b1;
        step(2);
        // R3: reserved code behaves as standby
        wcfg(2'b11, 4'd2, 1'b0);
        step(1);
        chk_bit("R3 reserved is standby", rd_out_oe, 1'b0);
        // R9: dual-head servo write
        stw_n = 1'b0; chip_id = 2'b11;
        wcfg(2'b10, 4'd4, 1'b1);
        step(1);
        chk_vec("R9 read single", rd_head_en, 12'h010);
        rw_n = 1'b0;
        step(2);
        chk_vec("R9 write pair", wr_head_en, 12'h410);
        chip_id = 2'b01;
        step(1);
        chk_vec("R9 qualifier missing", wr_head_en, 12'h010);
        chip_id = 2'b11;
        wcfg(2'b10, 4'd8, 1'b1);
        step(1);
        chk_vec("R9 upper head single", wr_head_en, 12'h100);
        // R11: leave active straight from write
        wcfg(2'b00, 4'd8, 1'b0);
        step(1);
        chk_bit("R11 wr_en off", wr_en, 1'b0);
        chk_bit("R11 sleep oe", rd_out_oe, 1'b0);
        // mixed stimulus compared every clock
        for (int i = 0; i < 4000; i++) begin
            rw_n    = ($urandom_range(0, 3) != 0);
            flt_det = ($urandom_range(0, 7) == 0);
            stw_n   = ($urandom_range(0, 1) == 1);
            chip_id = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 19) == 0) cfg_hold_n = ~cfg_hold_n;
            cfg_we   = ($urandom_range(0, 9) == 0);
            cfg_mode = ($urandom_range(0, 3) != 0) ? 2'b10 : 2'($urandom_range(0, 3));
            cfg_head = 4'($urandom_range(0, 15));
            cfg_dual = ($urandom_range(0, 1) == 1);
            step(1);
        end
        cfg_we = 1'b0;
        step(2);
        report();
        $finish;
    end
endmodule